// File: doc/BRIEF.md
# Masked Vector Lane Permute Unit

This block reorders the 32-bit lanes of a data vector under the control of a per-lane index vector. It works at two vector lengths: a narrow length of 8 lanes (256 bits) and a wide length of 16 lanes (512 bits). The block treats each lane as an opaque word and does no arithmetic on it. It sets no flags and signals no exceptions.

A request is presented with a one-cycle `in_valid` pulse. The data operand is either a full vector or a single 32-bit scalar that is copied into every data lane. A per-lane write mask then decides whether each destination lane receives the permuted word. A lane that is masked off either keeps the value supplied on `dest_old` (merging) or becomes zero (zeroing). In narrow mode, every result bit above the 8 active lanes is cleared. The result is registered and comes out one clock after the request, together with a one-cycle `out_valid`.

Top module: `lane_permute_unit`

## Requirements
- R1: Destination lane j of `result` equals the data lane whose number is held in the low bits of index lane j (index lane j occupies `index_vec[32j+31:32j]`, data lane k occupies `data_vec[32k+31:32k]`).
- R2: In narrow mode (`wide_mode`=0) only bits [2:0] of each index lane select a data lane. In wide mode (`wide_mode`=1) only bits [3:0] do. All other index bits have no effect on `result`.
- R3: Any data lane may feed several destination lanes in the same operation.
- R4: When `bcast_en`=1, every data lane is replaced by `scalar_val` before selection, and `data_vec` has no effect.
- R5: A destination lane whose `mask` bit is 1, or any lane when `mask_en`=0, receives the permuted word.
- R6: With `mask_en`=1 and `zero_mode`=0 (merging), a lane whose `mask` bit is 0 takes the matching lane of `dest_old`.
- R7: With `mask_en`=1 and `zero_mode`=1 (zeroing), a lane whose `mask` bit is 0 becomes zero.
- R8: In narrow mode, `result[511:256]` is zero whatever `dest_old` holds, and `mask[15:8]` has no effect.
- R9: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1. `result` changes only in that cycle and otherwise holds its value.
- R10: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; all inputs are captured at this edge |
| wide_mode | input | 1 | 1 selects 16 lanes, 0 selects 8 lanes |
| index_vec | input | 512 | Per-lane index words |
| data_vec | input | 512 | Data lanes to be permuted |
| scalar_val | input | 32 | Scalar copied into every data lane when broadcast is on |
| bcast_en | input | 1 | Broadcast `scalar_val` in place of `data_vec` |
| mask_en | input | 1 | 1 applies the write mask, 0 writes every active lane |
| mask | input | 16 | Per-lane write mask, bit j for lane j |
| zero_mode | input | 1 | Masked-off lanes: 1 writes zero, 0 keeps `dest_old` |
| dest_old | input | 512 | Current destination contents used for merging |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 512 | Registered permuted and masked vector |

## Verification
The assertions assume that every input is stable and free of unknowns at the clock edge where `in_valid` is high. They also assume that `rst` is released only on a clock boundary. The bench changes inputs only on falling edges, so each request is settled well before its capturing rising edge. The latency checks rely on `in_valid` being the only request strobe, so the bench drops `in_valid` on the falling edge after each request and leaves idle cycles between requests. That way the hold-value check is exercised between operations.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    localparam int LPU_LANE_W    = 32;
    localparam int LPU_MAX_LANES = 16;

    typedef enum logic {
        VL_NARROW = 1'b0,
        VL_WIDE   = 1'b1
    } vlen_e;

    typedef enum logic {
        MM_MERGE = 1'b0,
        MM_ZERO  = 1'b1
    } mmode_e;

    // Number of lanes active for a given length setting.
    function automatic int active_lane_count(input vlen_e vl, input int lanes);
        return (vl == VL_WIDE) ? lanes : lanes / 2;
    endfunction

    // A lane is written only when masking is off or its mask bit is set.
    function automatic logic lane_writes(input logic mask_on, input logic mask_bit);
        return (!mask_on) || mask_bit;
    endfunction

endpackage

// File: rtl/lpu_operand_fill.sv
module lpu_operand_fill #(
    parameter int LANE_W = lpu_pkg::LPU_LANE_W,
    parameter int LANES  = lpu_pkg::LPU_MAX_LANES,
    localparam int VEC_W = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]  data_in,
    input  logic [LANE_W-1:0] scalar_in,
    input  logic              bcast,
    output logic [VEC_W-1:0]  data_out
);

    for (genvar k = 0; k < LANES; k++) begin : g_fill
        assign data_out[k*LANE_W +: LANE_W] = bcast ? scalar_in
                                                    : data_in[k*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lpu_lane_xbar.sv
module lpu_lane_xbar #(
    parameter int LANE_W = lpu_pkg::LPU_LANE_W,
    parameter int LANES  = lpu_pkg::LPU_MAX_LANES,
    localparam int VEC_W = LANE_W * LANES,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] idx_vec,
    input  lpu_pkg::vlen_e   vlen,
    output logic [VEC_W-1:0] perm_vec
);
    import lpu_pkg::*;

    logic [LANE_W-1:0] src_lane [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_unpack
        assign src_lane[k] = src_vec[k*LANE_W +: LANE_W];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_dst
        logic [LANE_W-1:0] idx_word;
        logic [SEL_W-1:0]  sel;

        assign idx_word = idx_vec[j*LANE_W +: LANE_W];

        // Narrow length drops the top select bit so only the lower half is reachable.
        always_comb begin
            if (vlen == VL_WIDE) begin
                sel = idx_word[SEL_W-1:0];
            end else begin
                sel = {1'b0, idx_word[SEL_W-2:0]};
            end
        end

        assign perm_vec[j*LANE_W +: LANE_W] = src_lane[sel];
    end

endmodule

// File: rtl/lpu_mask_stage.sv
module lpu_mask_stage #(
    parameter int LANE_W = lpu_pkg::LPU_LANE_W,
    parameter int LANES  = lpu_pkg::LPU_MAX_LANES,
    localparam int VEC_W = LANE_W * LANES,
    localparam int HALF  = LANES / 2
) (
    input  logic [VEC_W-1:0] perm_vec,
    input  logic [VEC_W-1:0] old_vec,
    input  logic [LANES-1:0] lane_mask,
    input  logic             mask_on,
    input  lpu_pkg::mmode_e  mmode,
    input  lpu_pkg::vlen_e   vlen,
    output logic [VEC_W-1:0] final_vec
);
    import lpu_pkg::*;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic lane_active;
        logic lane_wr;

        if (j < HALF) begin : g_low
            assign lane_active = 1'b1;
        end else begin : g_high
            assign lane_active = (vlen == VL_WIDE);
        end

        assign lane_wr = lane_writes(mask_on, lane_mask[j]);

        always_comb begin
            if (!lane_active) begin
                final_vec[j*LANE_W +: LANE_W] = '0;
            end else if (lane_wr) begin
                final_vec[j*LANE_W +: LANE_W] = perm_vec[j*LANE_W +: LANE_W];
            end else if (mmode == MM_ZERO) begin
                final_vec[j*LANE_W +: LANE_W] = '0;
            end else begin
                final_vec[j*LANE_W +: LANE_W] = old_vec[j*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit #(
    parameter int LANE_W = lpu_pkg::LPU_LANE_W,
    parameter int LANES  = lpu_pkg::LPU_MAX_LANES,
    localparam int VEC_W = LANE_W * LANES,
    localparam int HALF  = LANES / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              wide_mode,
    input  logic [VEC_W-1:0]  index_vec,
    input  logic [VEC_W-1:0]  data_vec,
    input  logic [LANE_W-1:0] scalar_val,
    input  logic              bcast_en,
    input  logic              mask_en,
    input  logic [LANES-1:0]  mask,
    input  logic              zero_mode,
    input  logic [VEC_W-1:0]  dest_old,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result
);
    import lpu_pkg::*;

    vlen_e            vlen;
    mmode_e           mmode;
    logic [VEC_W-1:0] filled_vec;
    logic [VEC_W-1:0] perm_vec;
    logic [VEC_W-1:0] final_vec;
    vlen_e            res_vlen;

    assign vlen  = vlen_e'(wide_mode);
    assign mmode = mmode_e'(zero_mode);

    lpu_operand_fill #(.LANE_W(LANE_W), .LANES(LANES)) u_fill (
        .data_in   (data_vec),
        .scalar_in (scalar_val),
        .bcast     (bcast_en),
        .data_out  (filled_vec)
    );

    lpu_lane_xbar #(.LANE_W(LANE_W), .LANES(LANES)) u_xbar (
        .src_vec  (filled_vec),
        .idx_vec  (index_vec),
        .vlen     (vlen),
        .perm_vec (perm_vec)
    );

    lpu_mask_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_mask (
        .perm_vec  (perm_vec),
        .old_vec   (dest_old),
        .lane_mask (mask),
        .mask_on   (mask_en),
        .mmode     (mmode),
        .vlen      (vlen),
        .final_vec (final_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            out_valid <= 1'b0;
            res_vlen  <= VL_NARROW;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= final_vec;
                res_vlen <= vlen;
            end
        end
    end

    // R9: strobe follows the request by exactly one edge
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R10: reset empties the output stage
    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R8: inactive upper half reads zero in narrow results
    assert_upper_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && res_vlen == VL_NARROW) |-> (result[VEC_W-1:HALF*LANE_W] == '0));

    // R4: unmasked wide broadcast fills every lane with the scalar
    assert_bcast_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bcast_en && !mask_en && wide_mode)
            |=> (result == {LANES{$past(scalar_val)}}));

    // R6: a fully masked-off merge returns the old destination
    assert_merge_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !zero_mode && wide_mode && mask == '0)
            |=> (result == $past(dest_old)));

    // R7: a fully masked-off zeroing write clears everything
    assert_zero_all_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && zero_mode && mask == '0) |=> (result == '0));

endmodule

// File: tb/lane_permute_unit_tb.sv
module lane_permute_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 32;
    localparam int NL = 16;
    localparam int VW = LW * NL;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          wide_mode;
    logic [VW-1:0] index_vec;
    logic [VW-1:0] data_vec;
    logic [LW-1:0] scalar_val;
    logic          bcast_en;
    logic          mask_en;
    logic [NL-1:0] mask;
    logic          zero_mode;
    logic [VW-1:0] dest_old;
    logic          out_valid;
    logic [VW-1:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_permute_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
        .index_vec(index_vec), .data_vec(data_vec), .scalar_val(scalar_val),
        .bcast_en(bcast_en), .mask_en(mask_en), .mask(mask), .zero_mode(zero_mode),
        .dest_old(dest_old), .out_valid(out_valid), .result(result)
    );

    function automatic logic [VW-1:0] model(
        input logic w, input logic [VW-1:0] idx, input logic [VW-1:0] dat,
        input logic [LW-1:0] sc, input logic bc, input logic me,
        input logic [NL-1:0] mk, input logic zm, input logic [VW-1:0] old);
        logic [VW-1:0] r;
        r = '0;
        for (int j = 0; j < NL; j++) begin
            int active = w ? NL : NL / 2;
            int s;
            logic [LW-1:0] word;
            if (j < active) begin
                s = w ? int'(idx[j*LW +: 4]) : int'(idx[j*LW +: 3]);
                word = bc ? sc : dat[s*LW +: LW];
                if (!me || mk[j])  r[j*LW +: LW] = word;
                else if (zm)       r[j*LW +: LW] = '0;
                else               r[j*LW +: LW] = old[j*LW +: LW];
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int k = 0; k < NL; k++) v[k*LW +: LW] = $urandom;
        return v;
    endfunction

    function automatic logic [VW-1:0] make_idx(input int sel[NL], input logic [LW-1:0] junk);
        logic [VW-1:0] v;
        for (int k = 0; k < NL; k++) v[k*LW +: LW] = (junk & 32'hFFFF_FFF0) | LW'(sel[k]);
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic w, input logic [VW-1:0] idx,
                          input logic [VW-1:0] dat, input logic [LW-1:0] sc, input logic bc,
                          input logic me, input logic [NL-1:0] mk, input logic zm,
                          input logic [VW-1:0] old);
        logic [VW-1:0] exp;
        @(negedge clk);
        wide_mode = w; index_vec = idx; data_vec = dat; scalar_val = sc;
        bcast_en = bc; mask_en = me; mask = mk; zero_mode = zm; dest_old = old;
        in_valid = 1'b1;
        exp = model(w, idx, dat, sc, bc, me, mk, zm, old);
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(tag, result, exp);
        check_bit({tag, " R9 strobe"}, out_valid, 1'b1);
        // scramble inputs while idle: result must hold
        index_vec = rand_vec(); data_vec = rand_vec(); dest_old = rand_vec();
        @(negedge clk);
        check_bit("R9 strobe drop", out_valid, 1'b0);
        check_vec("R9 hold", result, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int sel[NL];
        logic [VW-1:0] d, o;
        void'($urandom(32'h1D2C_3B4A));
        rst = 1'b1; in_valid = 1'b0; wide_mode = 1'b0; index_vec = '0; data_vec = '0;
        scalar_val = '0; bcast_en = 1'b0; mask_en = 1'b0; mask = '0; zero_mode = 1'b0;
        dest_old = '0;
        repeat (3) @(negedge clk);
        check_bit("R10 reset valid", out_valid, 1'b0);
        check_vec("R10 reset result", result, '0);
        rst = 1'b0;

        // R1: identity and reversal
        for (int k = 0; k < NL; k++) sel[k] = k % 8;
        d = rand_vec();
        run_op("R1 identity narrow", 1'b0, make_idx(sel, '0), d, '0, 1'b0, 1'b0, '0, 1'b0, rand_vec());
        for (int k = 0; k < NL; k++) sel[k] = NL - 1 - k;
        run_op("R1 reverse wide", 1'b1, make_idx(sel, '0), d, '0, 1'b0, 1'b0, '0, 1'b0, rand_vec());

        // R2: upper index bits carry garbage; narrow also sees bit 3 set
        for (int k = 0; k < NL; k++) sel[k] = (k * 5 + 3) % NL;
        run_op("R2 junk bits wide", 1'b1, make_idx(sel, 32'hDEAD_BEE0), d, '0, 1'b0, 1'b0, '0, 1'b0, '0);
        run_op("R2 bit3 ignored narrow", 1'b0, make_idx(sel, 32'h8000_0000), d, '0, 1'b0, 1'b0, '0, 1'b0, '0);

        // R3: every lane picks the same source
        for (int k = 0; k < NL; k++) sel[k] = 6;
        run_op("R3 duplicate", 1'b1, make_idx(sel, '0), d, '0, 1'b0, 1'b0, '0, 1'b0, '0);

        // R4: broadcast at both lengths
        run_op("R4 broadcast wide", 1'b1, rand_vec(), rand_vec(), 32'h3F80_0000, 1'b1, 1'b0, '0, 1'b0, '0);
        run_op("R4 broadcast narrow", 1'b0, rand_vec(), rand_vec(), 32'hC0DE_0001, 1'b1, 1'b1, 16'h00A5, 1'b0, rand_vec());

        // R5: all-ones mask writes everything
        run_op("R5 all ones mask", 1'b1, rand_vec(), d, '0, 1'b0, 1'b1, 16'hFFFF, 1'b0, rand_vec());
        // R6: merge with empty and partial masks
        o = rand_vec();
        run_op("R6 merge empty mask", 1'b1, rand_vec(), d, '0, 1'b0, 1'b1, 16'h0000, 1'b0, o);
        run_op("R6 merge partial", 1'b1, rand_vec(), d, '0, 1'b0, 1'b1, 16'h5A3C, 1'b0, o);
        // R7: zeroing with empty and partial masks
        run_op("R7 zero empty mask", 1'b1, rand_vec(), d, '0, 1'b0, 1'b1, 16'h0000, 1'b1, o);
        run_op("R7 zero partial", 1'b0, rand_vec(), d, '0, 1'b0, 1'b1, 16'hC3F0, 1'b1, o);
        // R8: narrow with upper mask bits set and nonzero old contents
        run_op("R8 upper cleared", 1'b0, rand_vec(), d, '0, 1'b0, 1'b1, 16'hFF00, 1'b0, {VW{1'b1}});

        // Random mix over all modes
        for (int n = 0; n < 300; n++) begin
            run_op("R1 random mix", 1'($urandom), rand_vec(), rand_vec(), $urandom,
                   1'($urandom_range(0, 3) == 0), 1'($urandom), NL'($urandom),
                   1'($urandom), rand_vec());
        end

        // R10: reset mid-run clears a held result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_bit("R10 mid reset valid", out_valid, 1'b0);
        check_vec("R10 mid reset result", result, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule